// File: doc/BRIEF.md
# Reorder Buffer Retire Controller

This block keeps track of instructions that have been dispatched but not yet retired in an out-of-order core. It is a circular buffer of slots. Each dispatched instruction reserves a run of consecutive slots. The run length is the requested quantity, clamped so that it is at least one and at most the buffer depth. The instruction's token index is the position of the first slot of its run. The dispatcher reads the index on `disp_idx` in the same cycle that it issues the dispatch.

Execution units report completion by token index. Each cycle the controller walks forward from the oldest live instruction and retires executed instructions in program order. It stops at the first one that has not executed, or when it reaches the per-cycle retire cap. A cap of zero means there is no cap. Retired runs return their slots to the free pool. A combinational availability query tells the dispatcher whether a given quantity would fit.

Top module: `rob_retire_ctrl`

## Requirements
- R1: After reset the buffer is empty (`empty`=1), `ret_valid`=0 and `disp_idx`=0, and a query for the full depth reports `query_ok`=1.
- R2: A requested quantity of 0 reserves one slot, and a quantity above DEPTH reserves DEPTH slots. Both the dispatch path and the query path apply this rule. After an accepted dispatch, `disp_idx` becomes (old index + reserved slots) mod DEPTH.
- R3: `query_ok` is 1 exactly when the free slot count is at least the normalised `query_qty`.
- R4: A dispatch whose normalised quantity exceeds the free slot count raises `disp_err` in that cycle and reserves nothing. `disp_idx` and the free count stay unchanged.
- R5: Retirement is strictly in program order. An executed instruction never retires while an older live instruction is unexecuted.
- R6: At most MAX_RET instructions retire per cycle. With MAX_RET=0, every executed instruction in the contiguous run from the head retires in one cycle.
- R7: A completion reported in a cycle does not make that instruction retire in the same cycle. It becomes retirable from the next cycle.
- R8: Retiring an instruction frees its reserved slots at the clock edge. `empty` is 1 exactly when all DEPTH slots are free.
- R9: While instructions retire, `ret_valid`=1, `ret_cnt` gives how many retire at the coming edge, and `ret_idx`/`ret_tag` give the token index and tag of the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_qty | input | QTY_W | Requested slot count |
| disp_tag | input | TAG_W | Instruction reference stored with the token |
| disp_idx | output | IDX_W | Token index that a dispatch in this cycle receives |
| disp_err | output | 1 | Dispatch rejected for lack of slots |
| query_qty | input | QTY_W | Quantity for the availability query |
| query_ok | output | 1 | Query quantity fits in the free slots |
| cmpl_valid | input | 1 | Execution-complete report |
| cmpl_idx | input | IDX_W | Token index of the completed instruction |
| ret_valid | output | 1 | At least one instruction retires at the coming edge |
| ret_cnt | output | RCNT_W | Number of instructions retiring |
| ret_idx | output | IDX_W | Token index of the oldest retiring instruction |
| ret_tag | output | TAG_W | Tag of the oldest retiring instruction |
| empty | output | 1 | No slots are in use |

## Verification
The assertions assume that every completion names a live token that has not already completed. They also assume that completion indices are the ones `disp_idx` handed out and never stale or mid-run slots. The directed tests keep to this assumption: each completion uses an index recorded at dispatch, and each token completes exactly once. Dispatch is allowed to overrun free space, because rejection is itself checked behaviour.

// File: rtl/rob_pkg.sv
package rob_pkg;
    // Effective per-cycle retire cap: zero (or anything beyond depth) means depth.
    function automatic int retire_cap(int max_ret, int depth);
        return (max_ret == 0 || max_ret > depth) ? depth : max_ret;
    endfunction
endpackage

// File: rtl/rob_qnorm.sv
module rob_qnorm #(
    parameter int DEPTH = 16,
    parameter int QTY_W = 5,
    parameter int CNT_W = 5
) (
    input  logic [QTY_W-1:0] qty,
    output logic [CNT_W-1:0] slots
);
    always_comb begin
        if (qty == '0)
            slots = CNT_W'(1);
        else if (32'(qty) > DEPTH)
            slots = CNT_W'(DEPTH);
        else
            slots = CNT_W'(qty);
    end
endmodule

// File: rtl/rob_retire_scan.sv
module rob_retire_scan #(
    parameter int DEPTH  = 16,
    parameter int IDX_W  = 4,
    parameter int CNT_W  = 5,
    parameter int LIM    = 2,
    parameter int RCNT_W = 2
) (
    input  logic [IDX_W-1:0]             head,
    input  logic [CNT_W-1:0]             used,
    input  logic [DEPTH-1:0]             done,
    input  logic [DEPTH-1:0][CNT_W-1:0]  size,
    output logic [RCNT_W-1:0]            ret_cnt,
    output logic [CNT_W-1:0]             freed,
    output logic [IDX_W-1:0]             new_head
);
    logic [IDX_W-1:0]  ptr;
    logic [CNT_W-1:0]  walked;
    logic [CNT_W:0]    nxt;
    logic [RCNT_W-1:0] cnt;
    logic              stop;

    // Walk token starts from the head; each step consumes one run.
    always_comb begin
        ptr    = head;
        walked = '0;
        cnt    = '0;
        stop   = 1'b0;
        nxt    = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (!stop && walked < used && done[ptr] && cnt < RCNT_W'(LIM)) begin
                cnt    = cnt + RCNT_W'(1);
                walked = walked + size[ptr];
                nxt    = (CNT_W+1)'(ptr) + {1'b0, size[ptr]};
                if (nxt >= (CNT_W+1)'(DEPTH))
                    nxt = nxt - (CNT_W+1)'(DEPTH);
                ptr = nxt[IDX_W-1:0];
            end else begin
                stop = 1'b1;
            end
        end
        ret_cnt  = cnt;
        freed    = walked;
        new_head = ptr;
    end
endmodule

// File: rtl/rob_retire_ctrl.sv
module rob_retire_ctrl import rob_pkg::*; #(
    parameter int DEPTH   = 16,
    parameter int MAX_RET = 2,
    parameter int TAG_W   = 8,
    parameter int QTY_W   = 5
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             disp_valid,
    input  logic [QTY_W-1:0]                                 disp_qty,
    input  logic [TAG_W-1:0]                                 disp_tag,
    output logic [$clog2(DEPTH)-1:0]                         disp_idx,
    output logic                                             disp_err,
    input  logic [QTY_W-1:0]                                 query_qty,
    output logic                                             query_ok,
    input  logic                                             cmpl_valid,
    input  logic [$clog2(DEPTH)-1:0]                         cmpl_idx,
    output logic                                             ret_valid,
    output logic [$clog2(retire_cap(MAX_RET, DEPTH)+1)-1:0]  ret_cnt,
    output logic [$clog2(DEPTH)-1:0]                         ret_idx,
    output logic [TAG_W-1:0]                                 ret_tag,
    output logic                                             empty
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LIM    = retire_cap(MAX_RET, DEPTH);
    localparam int RCNT_W = $clog2(LIM + 1);

    typedef struct packed {
        logic [IDX_W-1:0]                head;
        logic [IDX_W-1:0]                tail;
        logic [CNT_W-1:0]                free;
        logic [DEPTH-1:0]                done;
        logic [DEPTH-1:0][CNT_W-1:0]     size;
        logic [DEPTH-1:0][TAG_W-1:0]     tag;
    } st_t;

    st_t st_q, st_d;

    logic [CNT_W-1:0]  disp_slots, query_slots, freed_d;
    logic [RCNT_W-1:0] scan_cnt;
    logic [IDX_W-1:0]  head_d;
    logic              disp_fire;
    logic [CNT_W:0]    tail_sum;

    rob_qnorm #(.DEPTH(DEPTH), .QTY_W(QTY_W), .CNT_W(CNT_W)) u_norm_disp (
        .qty(disp_qty), .slots(disp_slots));
    rob_qnorm #(.DEPTH(DEPTH), .QTY_W(QTY_W), .CNT_W(CNT_W)) u_norm_query (
        .qty(query_qty), .slots(query_slots));

    rob_retire_scan #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W),
                      .LIM(LIM), .RCNT_W(RCNT_W)) u_scan (
        .head    (st_q.head),
        .used    (CNT_W'(DEPTH) - st_q.free),
        .done    (st_q.done),
        .size    (st_q.size),
        .ret_cnt (scan_cnt),
        .freed   (freed_d),
        .new_head(head_d)
    );

    assign disp_fire = disp_valid && (st_q.free >= disp_slots);
    assign disp_err  = disp_valid && !(st_q.free >= disp_slots);
    assign disp_idx  = st_q.tail;
    assign query_ok  = st_q.free >= query_slots;
    assign ret_cnt   = scan_cnt;
    assign ret_valid = scan_cnt != '0;
    assign ret_idx   = st_q.head;
    assign ret_tag   = st_q.tag[st_q.head];
    assign empty     = st_q.free == CNT_W'(DEPTH);

    always_comb begin
        st_d      = st_q;
        st_d.head = head_d;
        tail_sum  = (CNT_W+1)'(st_q.tail) + {1'b0, disp_slots};
        if (tail_sum >= (CNT_W+1)'(DEPTH))
            tail_sum = tail_sum - (CNT_W+1)'(DEPTH);
        if (cmpl_valid)
            st_d.done[cmpl_idx] = 1'b1;
        if (disp_fire) begin
            st_d.done[st_q.tail] = 1'b0;
            st_d.size[st_q.tail] = disp_slots;
            st_d.tag[st_q.tail]  = disp_tag;
            st_d.tail            = tail_sum[IDX_W-1:0];
        end
        st_d.free = st_q.free - (disp_fire ? disp_slots : '0) + freed_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.free <= CNT_W'(DEPTH);
        end else begin
            st_q <= st_d;
        end
    end

    // R8: free pool never exceeds the buffer
    a_r8_free_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.free <= CNT_W'(DEPTH));
    // R4: a rejected dispatch leaves the allocation pointer alone
    a_r4_reject_holds_tail: assert property (@(posedge clk) disable iff (!rst_n)
        disp_err |=> st_q.tail == $past(st_q.tail));
    // R5: anything retiring starts at an executed head
    a_r5_head_first: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> st_q.done[st_q.head]);
    // R6: cap on retirements per cycle
    a_r6_retire_cap: assert property (@(posedge clk) disable iff (!rst_n)
        ret_cnt <= RCNT_W'(LIM));
    // R7: a completion of the unexecuted head cannot retire in its own cycle
    a_r7_no_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && cmpl_idx == st_q.head && !st_q.done[st_q.head]) |-> !ret_valid);
    // R8: empty buffer retires nothing
    a_r8_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !ret_valid);
endmodule

// File: tb/sim_rob_retire_ctrl.sv
`timescale 1ns/1ps
module sim_rob_retire_ctrl;
    localparam int DEPTH = 8;
    localparam int QTY_W = 5;
    localparam int TAG_W = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic disp_valid = 0;
    logic [QTY_W-1:0] disp_qty = '0;
    logic [TAG_W-1:0] disp_tag = '0;
    logic [QTY_W-1:0] query_qty = '0;
    logic cmpl_valid = 0;
    logic [2:0] cmpl_idx = '0;

    logic [2:0] disp_idx, ret_idx, disp_idx1, ret_idx1;
    logic disp_err, query_ok, ret_valid, empty;
    logic disp_err1, query_ok1, ret_valid1, empty1;
    logic [1:0] ret_cnt;
    logic [3:0] ret_cnt1;
    logic [TAG_W-1:0] ret_tag, ret_tag1;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rob_retire_ctrl #(.DEPTH(DEPTH), .MAX_RET(2), .TAG_W(TAG_W), .QTY_W(QTY_W)) u0 (
        .clk, .rst_n, .disp_valid, .disp_qty, .disp_tag, .disp_idx, .disp_err,
        .query_qty, .query_ok, .cmpl_valid, .cmpl_idx, .ret_valid, .ret_cnt,
        .ret_idx, .ret_tag, .empty);

    rob_retire_ctrl #(.DEPTH(DEPTH), .MAX_RET(0), .TAG_W(TAG_W), .QTY_W(QTY_W)) u1 (
        .clk, .rst_n, .disp_valid, .disp_qty, .disp_tag, .disp_idx(disp_idx1),
        .disp_err(disp_err1), .query_qty, .query_ok(query_ok1), .cmpl_valid, .cmpl_idx,
        .ret_valid(ret_valid1), .ret_cnt(ret_cnt1), .ret_idx(ret_idx1),
        .ret_tag(ret_tag1), .empty(empty1));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        rst_n = 0; disp_valid = 0; disp_qty = '0; disp_tag = '0;
        cmpl_valid = 0; cmpl_idx = '0; query_qty = '0;
        tick; tick;
        rst_n = 1;
        tick;
    endtask

    task automatic dispatch(input int q, input int tg);
        disp_valid = 1; disp_qty = QTY_W'(q); disp_tag = TAG_W'(tg);
        tick;
        disp_valid = 0;
    endtask

    task automatic complete(input int idx);
        cmpl_valid = 1; cmpl_idx = 3'(idx);
        tick;
        cmpl_valid = 0;
    endtask

    task automatic t_reset;
        do_reset;
        query_qty = 8; #1;
        chk("R1 empty", int'(empty), 1);
        chk("R1 ret_valid", int'(ret_valid), 0);
        chk("R1 disp_idx", int'(disp_idx), 0);
        chk("R1 query full depth", int'(query_ok), 1);
        query_qty = 20; #1;
        chk("R2 query clamp", int'(query_ok), 1);
    endtask

    task automatic t_norm_query;
        do_reset;
        dispatch(0, 5);
        chk("R2 zero qty takes one slot", int'(disp_idx), 1);
        dispatch(3, 6);
        chk("R2 next index", int'(disp_idx), 4);
        query_qty = 4; #1;
        chk("R3 query 4 of 4 free", int'(query_ok), 1);
        query_qty = 5; #1;
        chk("R3 query 5 of 4 free", int'(query_ok), 0);
        query_qty = 0; #1;
        chk("R3 query zero as one", int'(query_ok), 1);
    endtask

    task automatic t_reject_clamp;
        do_reset;
        dispatch(5, 1);
        disp_valid = 1; disp_qty = 4; disp_tag = 2; #1;
        chk("R4 disp_err", int'(disp_err), 1);
        tick;
        disp_valid = 0; query_qty = 3; #1;
        chk("R4 index kept", int'(disp_idx), 5);
        chk("R4 free kept", int'(query_ok), 1);
        complete(0);
        chk("R9 ret_idx single", int'(ret_idx), 0);
        chk("R9 ret_tag single", int'(ret_tag), 1);
        tick;
        chk("R8 empty after retire", int'(empty), 1);
        disp_valid = 1; disp_qty = 20; disp_tag = 3; #1;
        chk("R2 clamped dispatch fits", int'(disp_err), 0);
        tick;
        disp_valid = 0; query_qty = 1; #1;
        chk("R2 clamp filled buffer", int'(query_ok), 0);
        chk("R2 wrap index", int'(disp_idx), 5);
    endtask

    task automatic t_order_cap;
        do_reset;
        dispatch(1, 8'h11);
        dispatch(2, 8'h22);
        dispatch(1, 8'h33);
        dispatch(1, 8'h44);
        complete(1);
        complete(3);
        #1;
        chk("R5 younger waits", int'(ret_valid), 0);
        chk("R5 younger waits unlimited", int'(ret_valid1), 0);
        cmpl_valid = 1; cmpl_idx = 0; #1;
        chk("R7 no same-cycle retire", int'(ret_valid), 0);
        tick;
        cmpl_valid = 0; query_qty = 7; #1;
        chk("R6 capped count", int'(ret_cnt), 2);
        chk("R6 unlimited count", int'(ret_cnt1), 3);
        chk("R9 ret_idx", int'(ret_idx), 0);
        chk("R9 ret_tag", int'(ret_tag), 'h11);
        tick;
        chk("R9 second batch count", int'(ret_cnt), 1);
        chk("R9 second batch tag", int'(ret_tag), 'h33);
        query_qty = 6; #1;
        chk("R8 slots freed", int'(query_ok), 1);
        query_qty = 7; #1;
        chk("R8 not over-freed", int'(query_ok), 0);
        tick;
        chk("R5 stalls on unexecuted", int'(ret_valid), 0);
        chk("R8 not empty", int'(empty), 0);
        complete(4);
        chk("R9 last tag", int'(ret_tag), 'h44);
        tick;
        chk("R8 empty at end", int'(empty), 1);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset;
        t_norm_query;
        t_reject_clamp;
        t_order_cap;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule